// File: doc/BRIEF.md
# Peripheral Clock Enable with Debug Suspend

This block sits beside one peripheral and produces the clock-enable that paces it. A small control word, written and read over a plain register bus, holds an 8-bit rate field, a suspend-enable bit and a policy bit. The policy bit chooses how a debug halt takes effect. A non-zero rate field N yields a single-cycle enable pulse once every N bus clocks. A rate field of zero silences the peripheral completely.

When suspend is enabled and a debugger raises its halt request, the block stops passing enable pulses. In the careful policy it first lets the peripheral finish its current operation, which it learns from a busy input. In the quick policy it waits only until the pending bus transfer to the peripheral has drained. A build option fixes the quick policy for peripherals that cannot support the careful one. The two protected bits, suspend-enable and policy, can only change when the same write also sets a guard bit. That bit is never stored.

Top module: `periph_clk_ctrl`

## Requirements
- R1: After reset the rate field is 1, suspend-enable and policy are 0, the acknowledge is low, and `clk_en` is high in every cycle. `rd_data` reads 0x001.
- R2: `rd_data` returns the rate field in bits [7:0], suspend-enable in bit 8 and policy in bit 9. The guard bit (bit 10) and all higher bits read 0.
- R3: Suspend-enable (bit 8) and policy (bit 9) take the written values only when the same write has bit 10 set. Any other write leaves both unchanged but still updates the rate field.
- R4: A rate field of 0 keeps `clk_en` low in every cycle.
- R5: For a rate field N > 0, `clk_en` is a one-cycle pulse every N cycles. The count restarts on each write, so the first pulse falls in the Nth cycle after the write edge.
- R6: With suspend-enable at 0, `susp_req` has no effect: pulses continue and `susp_ack` stays low.
- R7: With policy 0 (careful), the pulses keep running while `mod_busy` is high. In the first cycle where `susp_req` is high and `mod_busy` is low, `susp_ack` goes high and `clk_en` is low.
- R8: With policy 1 (quick), gating begins in the first cycle where `susp_req` is high and `bus_pending` is low, whatever the state of `mod_busy`.
- R9: Once `susp_ack` is high, it stays high and `clk_en` stays low for as long as `susp_req` is held, even if busy or pending rise again. A divider tick that lands in the gating cycle itself is also blocked.
- R10: In the cycle `susp_req` falls, `susp_ack` is low. Pulses resume at the next tick of the divider, which keeps counting during the suspend.
- R11: With the parameter FAST_ONLY = 1, the quick policy applies even when the policy bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Write data: rate [7:0], suspend-enable 8, policy 9, guard 10 |
| rd_data | output | DATA_W | Control word read-back |
| susp_req | input | 1 | Debug halt request |
| mod_busy | input | 1 | Peripheral operation in progress |
| bus_pending | input | 1 | Bus transfer to the peripheral outstanding |
| clk_en | output | 1 | Peripheral clock-enable pulse |
| susp_ack | output | 1 | High while the peripheral is held |

## Verification
A divider tick and the start of a suspend can land in the same cycle. In that cycle the tick must be swallowed, and the acknowledge must still rise. The bench provokes this by setting the rate field to 3 and raising the halt request in exactly the cycle of the second tick after the write, with no transfer pending. The scoreboard expects `clk_en` low and `susp_ack` high in that cycle. After the request is dropped, it expects the next pulse on the divider's unchanged three-cycle grid.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   typedef enum logic {
      POL_CAREFUL = 1'b0,
      POL_QUICK   = 1'b1
   } pcc_policy_e;

   typedef struct packed {
      logic susp_en;
      logic policy;
   } pcc_guarded_t;
endpackage

// File: rtl/pcc_regs.sv
module pcc_regs #(
   parameter int DIV_W   = 8,
   parameter int DATA_W  = 16,
   parameter int DIV_RST = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DIV_W-1:0]      div_q,
   output pcc_pkg::pcc_guarded_t guard_q,
   output logic [DATA_W-1:0]     rd_data
);
   localparam int SUSP_POS  = DIV_W;
   localparam int POL_POS   = DIV_W + 1;
   localparam int GUARD_POS = DIV_W + 2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q           <= DIV_W'(DIV_RST);
         guard_q.susp_en <= 1'b0;
         guard_q.policy  <= 1'b0;
      end else if (wr_en) begin
         div_q <= wr_data[DIV_W-1:0];
         if (wr_data[GUARD_POS]) begin
            guard_q.susp_en <= wr_data[SUSP_POS];
            guard_q.policy  <= wr_data[POL_POS];
         end
      end
   end

   always_comb begin
      rd_data                = '0;
      rd_data[DIV_W-1:0]     = div_q;
      rd_data[SUSP_POS]      = guard_q.susp_en;
      rd_data[POL_POS]       = guard_q.policy;
   end
endmodule

// File: rtl/pcc_divider.sv
module pcc_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q >= div - DIV_W'(1));
   assign tick   = (div != '0) && (cnt_q == div - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || restart || div == '0) begin
         cnt_q <= '0;
      end else if (at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/pcc_suspend.sv
module pcc_suspend
   import pcc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        susp_en,
   input  pcc_policy_e policy,
   input  logic        req,
   input  logic        mod_busy,
   input  logic        bus_pending,
   input  logic        tick,
   output logic        clk_en,
   output logic        ack
);
   logic gated_q;
   logic safe_point;
   logic hold;

   always_comb begin
      safe_point = (policy == POL_QUICK) ? !bus_pending : !mod_busy;
      hold       = req && (gated_q || (susp_en && safe_point));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) gated_q <= 1'b0;
      else        gated_q <= hold;
   end

   assign clk_en = tick && !hold;
   assign ack    = hold;
endmodule

// File: rtl/periph_clk_ctrl.sv
module periph_clk_ctrl
   import pcc_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int DATA_W    = 16,
   parameter int DIV_RST   = 1,
   parameter bit FAST_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              susp_req,
   input  logic              mod_busy,
   input  logic              bus_pending,
   output logic              clk_en,
   output logic              susp_ack
);
   localparam int FIELD_BITS = DIV_W + 3;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (DATA_W < FIELD_BITS) begin : g_bad_data
         $error("DATA_W too narrow for the control word");
      end
      if (DIV_RST < 0 || DIV_RST >= (1 << DIV_W)) begin : g_bad_rst
         $error("DIV_RST out of range");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   pcc_guarded_t     guard_q;
   logic             tick;
   logic             fast_eff;
   pcc_policy_e      policy;

   pcc_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .DIV_RST(DIV_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .div_q   (div_q),
      .guard_q (guard_q),
      .rd_data (rd_data)
   );

   pcc_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_en),
      .div     (div_q),
      .tick    (tick)
   );

   generate
      if (FAST_ONLY) begin : g_quick_only
         assign fast_eff = 1'b1;
      end else begin : g_selectable
         assign fast_eff = guard_q.policy;
      end
   endgenerate

   assign policy = fast_eff ? POL_QUICK : POL_CAREFUL;

   pcc_suspend u_susp (
      .clk         (clk),
      .rst_n       (rst_n),
      .susp_en     (guard_q.susp_en),
      .policy      (policy),
      .req         (susp_req),
      .mod_busy    (mod_busy),
      .bus_pending (bus_pending),
      .tick        (tick),
      .clk_en      (clk_en),
      .ack         (susp_ack)
   );
endmodule

// File: rtl/pcc_chk.sv
module pcc_chk #(
   parameter int DIV_W  = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              susp_req,
   input logic              mod_busy,
   input logic              bus_pending,
   input logic              clk_en,
   input logic              susp_ack,
   input logic [DIV_W-1:0]  div_q,
   input logic              fast_eff
);
   localparam int SUSP_POS  = DIV_W;
   localparam int POL_POS   = DIV_W + 1;
   localparam int GUARD_POS = DIV_W + 2;

   // R3
   unguarded_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[GUARD_POS]) |=> $stable(rd_data[POL_POS:SUSP_POS]));

   // R4
   zero_rate_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == '0) |-> !clk_en);

   // R5
   pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && div_q > DIV_W'(1) && !wr_en) |=> !clk_en);

   // R6
   ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_ack) |-> rd_data[SUSP_POS]);

   // R7
   careful_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(susp_ack) && !fast_eff) |-> !mod_busy);

   // R8
   quick_waits_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(susp_ack) && fast_eff) |-> !bus_pending);

   // R9
   held_stays_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_ack && susp_req) |=> (!susp_req || susp_ack));

   // R10
   release_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !susp_req |-> !susp_ack);
endmodule

bind periph_clk_ctrl pcc_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .susp_req    (susp_req),
   .mod_busy    (mod_busy),
   .bus_pending (bus_pending),
   .clk_en      (clk_en),
   .susp_ack    (susp_ack),
   .div_q       (div_q),
   .fast_eff    (fast_eff)
);

// File: tb/periph_clk_ctrl_tb.sv
module periph_clk_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          susp_req = 1'b0;
   logic          mod_busy = 1'b0;
   logic          bus_pending = 1'b0;
   logic [DW-1:0] rd_data, rd_data_fo;
   logic          clk_en, susp_ack, clk_en_fo, susp_ack_fo;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;

   typedef struct {
      string tag;
      bit    fo;
      bit    en;
      bit    ack;
   } item_t;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   periph_clk_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .susp_req(susp_req), .mod_busy(mod_busy),
      .bus_pending(bus_pending), .clk_en(clk_en), .susp_ack(susp_ack)
   );

   periph_clk_ctrl #(.FAST_ONLY(1'b1)) u_dut_fo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data_fo), .susp_req(susp_req), .mod_busy(mod_busy),
      .bus_pending(bus_pending), .clk_en(clk_en_fo), .susp_ack(susp_ack_fo)
   );

   // monitor: pops one expected item per cycle, mid-cycle
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         logic  a_en, a_ack;
         it    = sb_q.pop_front();
         a_en  = it.fo ? clk_en_fo : clk_en;
         a_ack = it.fo ? susp_ack_fo : susp_ack;
         n_checks++;
         if (a_en !== it.en || a_ack !== it.ack) begin
            n_errors++;
            $display("FAIL %s: clk_en/ack actual %b/%b expected %b/%b",
                     it.tag, a_en, a_ack, it.en, it.ack);
         end
      end
   end

   // driver side: expected pulses on a grid of the rate field
   task automatic seg(input string tag, input bit fo, input int first_idx,
                      input int n, input int period, input bit gated);
      for (int i = 0; i < n; i++) begin
         item_t it;
         int    idx;
         idx    = first_idx + i;
         it.tag = tag;
         it.fo  = fo;
         it.ack = gated;
         it.en  = !gated && period != 0 && (idx % period == 0);
         sb_q.push_back(it);
      end
      repeat (n) @(negedge clk);
   endtask

   task automatic write_word(input logic [DW-1:0] v);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_data = v;
      @(posedge clk); #1;
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic check_rd(input string tag, input logic [DW-1:0] exp);
      n_checks++;
      if (rd_data !== exp) begin
         n_errors++;
         $display("FAIL %s: rd_data actual %h expected %h", tag, rd_data, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check_rd("R1 reset read", 16'h0001);
      seg("R1 reset pulses", 1'b0, 1, 4, 1, 1'b0);

      // R3 unguarded write: protected bits stay, rate becomes 0
      write_word(16'h0300);
      check_rd("R3 unguarded write", 16'h0000);
      // R4 zero rate silences the enable
      seg("R4 rate zero", 1'b0, 1, 8, 0, 1'b0);

      // R2 guarded write, guard bit reads 0
      write_word(16'h0703);
      check_rd("R2 read-back guard zero", 16'h0303);
      // R5 rate 3
      seg("R5 rate 3", 1'b0, 1, 12, 3, 1'b0);

      // R3 unguarded write keeps bits 8/9, R5 rate 5
      write_word(16'h0005);
      check_rd("R3 protected bits kept", 16'h0305);
      seg("R5 rate 5", 1'b0, 1, 15, 5, 1'b0);

      // R6 suspend disabled: request ignored
      write_word(16'h0401);
      check_rd("R3 guarded clear", 16'h0001);
      step(); susp_req = 1'b1; mod_busy = 1'b0; bus_pending = 1'b0;
      seg("R6 request ignored", 1'b0, 1, 5, 1, 1'b0);
      step(); susp_req = 1'b0;

      // R7 careful policy
      write_word(16'h0501);
      check_rd("R2 careful setup", 16'h0101);
      step(); mod_busy = 1'b1; bus_pending = 1'b0; susp_req = 1'b1;
      seg("R7 busy keeps clock", 1'b0, 1, 3, 1, 1'b0);
      step(); mod_busy = 1'b0;
      seg("R7 gate on finish", 1'b0, 1, 1, 1, 1'b1);
      step(); mod_busy = 1'b1;
      seg("R9 careful held", 1'b0, 1, 3, 1, 1'b1);
      step(); susp_req = 1'b0;
      seg("R10 careful release", 1'b0, 1, 3, 1, 1'b0);

      // R8 quick policy
      write_word(16'h0701);
      check_rd("R2 quick setup", 16'h0301);
      step(); mod_busy = 1'b1; bus_pending = 1'b1; susp_req = 1'b1;
      seg("R8 pending keeps clock", 1'b0, 1, 2, 1, 1'b0);
      step(); bus_pending = 1'b0;
      seg("R8 gate after transfer", 1'b0, 1, 1, 1, 1'b1);
      step(); bus_pending = 1'b1;
      seg("R9 quick held", 1'b0, 1, 2, 1, 1'b1);
      step(); susp_req = 1'b0;
      seg("R10 quick release", 1'b0, 1, 2, 1, 1'b0);

      // R9/R10 gating lands on a tick, release resumes on the grid
      bus_pending = 1'b0; mod_busy = 1'b1;
      write_word(16'h0703);
      seg("R5 grid before halt", 1'b0, 1, 3, 3, 1'b0);
      step();
      seg("R5 grid before halt", 1'b0, 4, 2, 3, 1'b0);
      step(); susp_req = 1'b1;
      seg("R9 tick in gating cycle", 1'b0, 6, 2, 3, 1'b1);
      step(); susp_req = 1'b0;
      seg("R10 resume on next tick", 1'b0, 8, 5, 3, 1'b0);

      // R11 quick-only variant ignores the policy bit
      write_word(16'h0501);
      step(); mod_busy = 1'b1; bus_pending = 1'b1; susp_req = 1'b1;
      seg("R11 variant pending", 1'b1, 1, 2, 1, 1'b0);
      step(); bus_pending = 1'b0;
      seg("R11 variant gates on bus", 1'b1, 1, 2, 1, 1'b1);
      step(); susp_req = 1'b0; mod_busy = 1'b0;
      seg("R11 variant release", 1'b1, 1, 2, 1, 1'b0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule